// File: doc/BRIEF.md
# Timebase Divider with Second Latch

This block is a free-running 15-bit timebase that advances once per enable pulse from a 32.768 kHz oscillator. Its top bit toggles with a full period of one second, so a core can poll it as a seconds level. Two fixed tap bits are exposed for the core's timer-test operations. The top four bits are exposed as a nibble for a read-to-accumulator operation.

A sticky latch records each rising edge of the seconds level. The core polls and clears the latch with a single test-and-clear command. That command also returns a flag that is high while the seconds level is low.

A divider-clear command has two modes, picked by a mode select:
- **Full clear** zeroes the whole count.
- **Partial clear** zeroes the count but keeps its low six bits.

The count path is a four-action decoder: HOLD, STEP, ZERO and KEEP_LOW. The latch is a two-state machine:
- **IDLE** means no second has elapsed since the last clear.
- **LATCHED** means a second has elapsed.
- Transition **SET**: IDLE/LATCHED → LATCHED when the seconds level rises.
- Transition **CLEAR**: LATCHED/IDLE → IDLE when the test command is given and the level does not rise in that cycle.

Top module: `timebase_divider`

## Requirements
- R1: While `rst_n` is low, the count is zero and the latch is in IDLE. All outputs then read 0.
- R2: With no clear, each cycle with `tick_en` high adds 1 to the 15-bit count, wrapping from 0x7FFF to 0. A cycle with `tick_en` low leaves the count unchanged.
- R3: `f1_tap` equals count bit 14, and `f4_tap` equals count bit 11 (bit 0 is the least significant).
- R4: `sec_level` equals count bit 14. Counting up from zero, it first goes high after 16384 ticks, and its period is 32768 ticks.
- R5: On the clock edge where `sec_level` goes from 0 to 1, `gamma` becomes 1 at the same edge (transition SET). Otherwise it holds until it is cleared.
- R6: When `sec_test` is high, `sec_test_skip` equals NOT `sec_level` in that same cycle. `gamma` is 0 after that edge (transition CLEAR), unless R7 applies.
- R7: If `sec_test` is high in the cycle in which `sec_level` rises, `gamma` is 1 after that edge.
- R8: `div_clear` high with `keep_low` low sets the whole count to 0 at the next edge.
- R9: `div_clear` high with `keep_low` high sets count bits 14..6 to 0 and leaves bits 5..0 unchanged.
- R10: `div_clear` takes priority over `tick_en` in the same cycle. No increment happens in that cycle.
- R11: `div_nibble` equals count bits 14..11, with bit 14 as its MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One pulse per 32.768 kHz oscillator period |
| div_clear | input | 1 | Divider-clear command |
| keep_low | input | 1 | Clear mode: 0 = full clear, 1 = keep low six bits |
| sec_test | input | 1 | Test-and-clear command for the second latch |
| f1_tap | output | 1 | Count bit 14 |
| f4_tap | output | 1 | Count bit 11 |
| sec_level | output | 1 | One-second level (count bit 14) |
| gamma | output | 1 | Sticky second-elapsed latch |
| sec_test_skip | output | 1 | High when `sec_test` is high and `sec_level` is low |
| div_nibble | output | 4 | Count bits 14..11 |

## Verification
Two situations are hard to reach from the ports.

The first is a test-and-clear that lands in the very cycle the seconds level rises. The bench reaches it by clearing to zero and giving exactly 16383 ticks. It then raises `sec_test` together with the 16384th tick.

The second is the partial clear. Its retained low bits are invisible at the ports. The bench proves they were kept by checking the taps on every later cycle against an arithmetic model, so the first `f4_tap` rise comes 2048 minus the kept value ticks after the clear. Full sweeps past the 16384- and 32768-tick marks cover the tap, level and wrap behaviour.

// File: rtl/timebase_pkg.sv
package timebase_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD     = 2'd0,
        ACT_STEP     = 2'd1,
        ACT_ZERO     = 2'd2,
        ACT_KEEP_LOW = 2'd3
    } count_act_t;

    typedef enum logic {
        GAM_IDLE    = 1'b0,
        GAM_LATCHED = 1'b1
    } gam_state_t;

endpackage

// File: rtl/timebase_counter.sv
module timebase_counter
    import timebase_pkg::*;
#(
    parameter int CNT_W   = 15,
    parameter int SEC_BIT = 14,
    parameter int KEEP_LO = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             div_clear,
    input  logic             keep_low,
    output logic [CNT_W-1:0] count,
    output logic             sec_rise
);

    localparam logic [CNT_W-1:0] LO_MASK =
        {{(CNT_W-KEEP_LO){1'b0}}, {KEEP_LO{1'b1}}};

    count_act_t       act;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    // Action decode: clear outranks the tick.
    always_comb begin
        if (div_clear)
            act = keep_low ? ACT_KEEP_LOW : ACT_ZERO;
        else if (tick_en)
            act = ACT_STEP;
        else
            act = ACT_HOLD;
    end

    assign cnt_inc = cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                ACT_HOLD:     cnt_q <= cnt_q;
                ACT_STEP:     cnt_q <= cnt_inc;
                ACT_ZERO:     cnt_q <= '0;
                ACT_KEEP_LOW: cnt_q <= cnt_q & LO_MASK;
                default:      cnt_q <= cnt_q;
            endcase
        end
    end

    assign count    = cnt_q;
    assign sec_rise = (act == ACT_STEP) && cnt_inc[SEC_BIT] && !cnt_q[SEC_BIT];

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !div_clear) |=> $stable(cnt_q));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !div_clear) |=> (cnt_q == $past(cnt_q) + 1'b1));
    p_full_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_clear && !keep_low) |=> (cnt_q == '0));
    p_keep_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (div_clear && keep_low) |=> (cnt_q == ($past(cnt_q) & LO_MASK)));
    p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_rise |=> cnt_q[SEC_BIT]);

endmodule

// File: rtl/timebase_gamma_fsm.sv
module timebase_gamma_fsm
    import timebase_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sec_rise,
    input  logic sec_test,
    output logic gamma
);

    gam_state_t state_q;
    gam_state_t state_d;

    // Next state: SET beats CLEAR.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GAM_IDLE: begin
                if (sec_rise) state_d = GAM_LATCHED;
            end
            GAM_LATCHED: begin
                if (!sec_rise && sec_test) state_d = GAM_IDLE;
            end
            default: state_d = GAM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GAM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            GAM_IDLE:    gamma = 1'b0;
            GAM_LATCHED: gamma = 1'b1;
            default:     gamma = 1'b0;
        endcase
    end

    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sec_rise |=> gamma);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_test && !sec_rise) |=> !gamma);
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_test && !sec_rise) |=> $stable(gamma));

endmodule

// File: rtl/timebase_divider.sv
module timebase_divider
    import timebase_pkg::*;
#(
    parameter int CNT_W   = 15,
    parameter int F1_BIT  = 14,
    parameter int F4_BIT  = 11,
    parameter int KEEP_LO = 6,
    parameter int NIB_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             div_clear,
    input  logic             keep_low,
    input  logic             sec_test,
    output logic             f1_tap,
    output logic             f4_tap,
    output logic             sec_level,
    output logic             gamma,
    output logic             sec_test_skip,
    output logic [NIB_W-1:0] div_nibble
);

    localparam int SEC_BIT = CNT_W - 1;

    logic [CNT_W-1:0] count;
    logic             sec_rise;

    timebase_counter #(
        .CNT_W  (CNT_W),
        .SEC_BIT(SEC_BIT),
        .KEEP_LO(KEEP_LO)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .div_clear(div_clear),
        .keep_low (keep_low),
        .count    (count),
        .sec_rise (sec_rise)
    );

    timebase_gamma_fsm u_gamma (
        .clk     (clk),
        .rst_n   (rst_n),
        .sec_rise(sec_rise),
        .sec_test(sec_test),
        .gamma   (gamma)
    );

    assign f1_tap        = count[F1_BIT];
    assign f4_tap        = count[F4_BIT];
    assign sec_level     = count[SEC_BIT];
    assign sec_test_skip = sec_test && !count[SEC_BIT];
    assign div_nibble    = count[CNT_W-1 -: NIB_W];

    p_level_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sec_level) && sec_level) |-> gamma);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |-> (div_nibble == '0 && !gamma));

endmodule

// File: tb/timebase_divider_test.sv
module timebase_divider_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_en, div_clear, keep_low, sec_test;
    logic       f1_tap, f4_tap, sec_level, gamma, sec_test_skip;
    logic [3:0] div_nibble;

    int checks = 0;
    int errors = 0;
    int m_cnt  = 0;
    bit m_gam  = 1'b0;

    always #4 clk = ~clk;

    timebase_divider uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .div_clear(div_clear),
        .keep_low(keep_low), .sec_test(sec_test), .f1_tap(f1_tap),
        .f4_tap(f4_tap), .sec_level(sec_level), .gamma(gamma),
        .sec_test_skip(sec_test_skip), .div_nibble(div_nibble)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_outs(string tag);
        chk({tag, " R3 f1"}, int'(f1_tap), (m_cnt >> 14) & 1);
        chk({tag, " R3 f4"}, int'(f4_tap), (m_cnt >> 11) & 1);
        chk({tag, " R4 level"}, int'(sec_level), (m_cnt >> 14) & 1);
        chk({tag, " R11 nibble"}, int'(div_nibble), (m_cnt >> 11) & 15);
        chk({tag, " R5 gamma"}, int'(gamma), int'(m_gam));
    endtask

    // One cycle: drive inputs, check the combinational skip flag,
    // take the edge, update the model, then check the outputs.
    task automatic step(bit tk, bit clr, bit kl, bit tst, string tag);
        bit rise;
        tick_en = tk; div_clear = clr; keep_low = kl; sec_test = tst;
        #2;
        if (tst)
            chk({tag, " R6 skip"}, int'(sec_test_skip), ((m_cnt >> 14) & 1) ^ 1);
        rise = tk && !clr && ((m_cnt & 16'h7FFF) == 16'h3FFF);
        if (clr)     m_cnt = kl ? (m_cnt & 63) : 0;
        else if (tk) m_cnt = (m_cnt + 1) & 16'h7FFF;
        if (rise)     m_gam = 1'b1;
        else if (tst) m_gam = 1'b0;
        @(posedge clk);
        #1;
        check_outs(tag);
    endtask

    initial begin
        #(8 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick_en = 1'b1; div_clear = 1'b0; keep_low = 1'b0; sec_test = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_outs("R1 reset");
        chk("R1 skip", int'(sec_test_skip), 0);
        rst_n = 1'b1;

        // Full sweep past the first second and through the wrap
        for (int i = 0; i < 32768 + 100; i++) step(1, 0, 0, 0, "R2 sweep");
        chk("R5 gamma sticky across wrap", int'(gamma), 1);

        // Test-and-clear while the level is low: skip high, latch cleared
        step(0, 0, 0, 1, "R6 test low");
        chk("R6 cleared", int'(gamma), 0);

        // Enable held low mixed with ticks
        for (int i = 0; i < 300; i++) step(i % 3 == 0, 0, 0, 0, "R2 gated");

        // Full clear, then clear racing a tick
        for (int i = 0; i < 5000; i++) step(1, 0, 0, 0, "R2 run");
        step(0, 1, 0, 0, "R8 full clear");
        chk("R8 nibble zero", int'(div_nibble), 0);
        for (int i = 0; i < 2100; i++) step(1, 0, 0, 0, "R8 after");
        step(1, 1, 0, 0, "R10 clear beats tick");
        chk("R10 nibble zero", int'(div_nibble), 0);

        // Collision: rise and test in the same cycle
        for (int i = 0; i < 16383; i++) step(1, 0, 0, 0, "R7 approach");
        chk("R7 level still low", int'(sec_level), 0);
        step(1, 0, 0, 1, "R7 collision");
        chk("R7 set wins", int'(gamma), 1);
        step(0, 0, 0, 1, "R6 test high");
        chk("R6 cleared high", int'(gamma), 0);

        // Partial clear: low six bits shape the tap timing afterwards
        for (int i = 0; i < 1234; i++) step(1, 0, 0, 0, "R9 approach");
        step(1, 1, 1, 0, "R9 keep low");
        chk("R9 nibble zero", int'(div_nibble), 0);
        for (int i = 0; i < 2100; i++) step(1, 0, 0, 0, "R9 timing");
        for (int i = 0; i < 777; i++) step(1, 0, 0, 0, "R9 second run");
        step(0, 1, 1, 0, "R9 keep low idle");
        for (int i = 0; i < 4200; i++) step(1, 0, 0, 0, "R9 timing2");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule